// File: doc/BRIEF.md
# Hybrid Asymmetric Multilevel Modulator

This block produces the per-cell output levels for one phase of a cascaded inverter whose series cells differ in level count and voltage step. Each sample, a signed fixed-point reference arrives with a strobe. The highest-voltage cell quantises it to a staircase against offset thresholds. The part that cell could not produce is handed to the cell below, and the process repeats down the chain. Only the lowest cell, whose step is the per-unit base, switches at high frequency. It compares its leftover reference against an internal triangle carrier and updates every clock.

Cell level counts, cell steps, the reference width and fraction, and the carrier half-period are parameters. The default arrangement has a two-level cell with step 1, a three-level cell with step 1 and a five-level cell with step 3, ordered from lowest to highest. All voltages leave the block in half-per-unit integers, so that cells with an even number of levels are represented exactly. The phase output is the sum of the cell outputs.

The triangle carrier is a two-state machine. `CARR_RISE` counts up from 0 and moves to `CARR_FALL` when the count reaches the half-period. `CARR_FALL` counts down and moves back to `CARR_RISE` when the count reaches 0. After reset the carrier starts in `CARR_RISE` at 0, and one full period is twice the half-period in clocks.

Top module: `hml_modulator`

## Requirements
- R1: After reset every cell output, the phase output and the result strobe are zero. They stay zero, including the lowest cell, until the first result leaves the pipeline.
- R2: A reference sampled with the strobe at clock edge e produces its result at edge e+N_CELLS, and `out_valid` is high for that one cycle. Outputs of the higher cells change only at such an edge.
- R3: A stepped cell with an odd level count m and step V reports a half-per-unit value of ±2·k·V. Here k counts its thresholds δ+(i−1)·V, for i = 1..(m−1)/2, that the reference magnitude reaches or exceeds. δ is half the sum of (m_k−1)·V_k over the lower cells. The sign follows the reference, and negative references use the mirrored thresholds.
- R4: A stepped cell with an even level count reports ±(2k+1)·V half-units, where k counts the thresholds δ+(2i−1)·V/2 that are reached, for i = 1..(m−2)/2. A reference of zero or above gives the positive value.
- R5: The reference of each lower cell is the reference of the cell above minus the voltage that cell actually chose.
- R6: The lowest cell (step 1 pu) takes the nearest level at or below its residual. It moves one level up while the residual's excess over that level, as a fraction of 1 pu, is strictly greater than the carrier, that is, the count divided by the half-period. This decision is re-evaluated on every clock.
- R7: When the residual is at or above the lowest cell's top level, that cell stays at its top level. When it is below the bottom level, it stays at its bottom level. In both cases it does not switch.
- R8: `phase_out` equals the sum of the cell outputs in half-per-unit. The default arrangement reaches all 16 odd half-unit values from −15 to +15.
- R9: Strobes on consecutive clocks each produce their own result, in order, one clock apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | Strobe that latches `ref_in` |
| ref_in | input | REF_W | Signed reference, FRAC_W fractional bits of a per-unit |
| cell_out | output | N_CELLS*OUT_W | Signed half-per-unit voltage per cell, cell 0 (lowest) in the low slice |
| phase_out | output | OUT_W | Signed half-per-unit phase voltage |
| out_valid | output | 1 | High for the cycle in which a new result appears |

## Verification
The hardest condition to reach from the ports is a residual that lands exactly on a threshold or a level boundary of a lower cell while the carrier is at a particular phase. Whether that happens depends on the quantisation in every cell above. The bench handles this with a slow reference ramp in steps of about 1/20 pu, each step held for more than one carrier period. This walks every threshold crossing of the chain against every carrier phase. A second instance with an even-level top cell receives directed references on both sides of its threshold. Consecutive strobes and references beyond the range are applied as directed sequences.

// File: rtl/hml_pkg.sv
package hml_pkg;

    localparam int MAX_CELLS = 8;

    typedef enum logic {CARR_RISE, CARR_FALL} carr_state_e;

    // Twice the threshold offset of cell 'upto': sum over lower cells of (levels-1)*step
    function automatic int half_offset(input logic [8*MAX_CELLS-1:0] lv,
                                       input logic [8*MAX_CELLS-1:0] st,
                                       input int upto);
        int acc;
        acc = 0;
        for (int k = 0; k < MAX_CELLS; k++) begin
            if (k < upto) acc += (int'(lv[8*k +: 8]) - 1) * int'(st[8*k +: 8]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/hml_carrier.sv
module hml_carrier
    import hml_pkg::*;
#(
    parameter int HALF = 16,
    parameter int CW   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] carr
);

    carr_state_e   state_q, state_d;
    logic [CW-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CARR_RISE;
            carr    <= '0;
        end else begin
            state_q <= state_d;
            carr    <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = carr;
        unique case (state_q)
            CARR_RISE: begin
                if (carr == CW'(HALF - 1)) begin
                    cnt_d   = CW'(HALF);
                    state_d = CARR_FALL;
                end else begin
                    cnt_d = carr + 1'b1;
                end
            end
            CARR_FALL: begin
                if (carr == CW'(1)) begin
                    cnt_d   = '0;
                    state_d = CARR_RISE;
                end else begin
                    cnt_d = carr - 1'b1;
                end
            end
        endcase
    end

endmodule

// File: rtl/hml_step_cell.sv
module hml_step_cell #(
    parameter int LEVELS    = 3,
    parameter int STEP      = 1,
    parameter int OFFS_HALF = 0,
    parameter int SLOT      = 1,
    parameter int N_CELLS   = 3,
    parameter int IW        = 20,
    parameter int OW        = 8,
    parameter int FRAC_W    = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_vld,
    input  logic signed [IW-1:0]   in_res,
    input  logic [N_CELLS*OW-1:0]  in_volts,
    output logic                   out_vld,
    output logic signed [IW-1:0]   out_res,
    output logic [N_CELLS*OW-1:0]  out_volts
);

    localparam bit ODD    = (LEVELS % 2) == 1;
    localparam int N_THR  = ODD ? (LEVELS - 1) / 2 : (LEVELS - 2) / 2;
    localparam int HALF_U = 1 << (FRAC_W - 1);
    localparam int BASE_U = OFFS_HALF * HALF_U;

    logic signed [IW-1:0]  mag;
    logic signed [IW-1:0]  chosen_u;
    logic signed [IW-1:0]  resid;
    logic [N_CELLS*OW-1:0] volts_d;
    int                    hits;
    int                    lvl_half;

    always_comb begin
        mag  = in_res[IW-1] ? -in_res : in_res;
        hits = 0;
        for (int i = 1; i <= N_THR; i++) begin
            if (int'(mag) >= BASE_U + (ODD ? 2 * (i - 1) * STEP * HALF_U
                                           : (2 * i - 1) * STEP * HALF_U))
                hits = hits + 1;
        end
        lvl_half = ODD ? 2 * hits * STEP : (2 * hits + 1) * STEP;
        if (in_res[IW-1]) lvl_half = -lvl_half;
        chosen_u = IW'(lvl_half * HALF_U);
        resid    = in_res - chosen_u;
        volts_d  = in_volts;
        volts_d[SLOT*OW +: OW] = OW'(lvl_half);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_res   <= '0;
            out_volts <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_res   <= resid;
                out_volts <= volts_d;
            end
        end
    end

endmodule

// File: rtl/hml_pwm_cell.sv
module hml_pwm_cell #(
    parameter int LEVELS    = 2,
    parameter int IW        = 20,
    parameter int OW        = 8,
    parameter int FRAC_W    = 10,
    parameter int CARR_HALF = 16,
    parameter int CW        = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [IW-1:0] res_in,
    input  logic [CW-1:0]        carr,
    output logic signed [OW-1:0] volt_out
);

    localparam int ONE_U = 1 << FRAC_W;
    localparam int OFF_U = (LEVELS - 1) * (ONE_U / 2);

    logic signed [IW-1:0] held_res;
    logic signed [IW-1:0] use_res;
    logic                 armed;
    logic                 sat_lo, sat_hi, go_up;
    int                   shifted, lower, frac, idx;

    always_comb begin
        use_res = load ? res_in : held_res;
        shifted = int'(use_res) + OFF_U;
        sat_lo  = shifted < 0;
        lower   = sat_lo ? 0 : (shifted >>> FRAC_W);
        sat_hi  = lower >= LEVELS - 1;
        if (sat_hi) lower = LEVELS - 2;
        frac    = shifted - lower * ONE_U;
        go_up   = sat_hi || (!sat_lo && (frac * CARR_HALF > int'(carr) * ONE_U));
        idx     = lower + (go_up ? 1 : 0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_res <= '0;
            armed    <= 1'b0;
            volt_out <= '0;
        end else begin
            if (load) begin
                held_res <= res_in;
                armed    <= 1'b1;
            end
            if (load || armed) volt_out <= OW'(2 * idx - (LEVELS - 1));
        end
    end

endmodule

// File: rtl/hml_modulator.sv
module hml_modulator
    import hml_pkg::*;
#(
    parameter int                   N_CELLS     = 3,
    parameter logic [8*N_CELLS-1:0] CELL_LEVELS = {8'd5, 8'd3, 8'd2},
    parameter logic [8*N_CELLS-1:0] CELL_STEPS  = {8'd3, 8'd1, 8'd1},
    parameter int                   REF_W       = 16,
    parameter int                   FRAC_W      = 10,
    parameter int                   OUT_W       = 8,
    parameter int                   CARR_HALF   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_valid,
    input  logic signed [REF_W-1:0]    ref_in,
    output logic [N_CELLS*OUT_W-1:0]   cell_out,
    output logic signed [OUT_W-1:0]    phase_out,
    output logic                       out_valid
);

    localparam int IW = REF_W + 4;
    localparam int OW = OUT_W;
    localparam int CW = $clog2(CARR_HALF + 1);
    localparam int NS = N_CELLS - 1;
    localparam logic [8*MAX_CELLS-1:0] LV_X = (8*MAX_CELLS)'(CELL_LEVELS);
    localparam logic [8*MAX_CELLS-1:0] ST_X = (8*MAX_CELLS)'(CELL_STEPS);

    logic                   lat_vld;
    logic signed [IW-1:0]   lat_res;
    logic                   stg_vld   [NS];
    logic signed [IW-1:0]   stg_res   [NS];
    logic [N_CELLS*OW-1:0]  stg_volts [NS];
    logic [N_CELLS*OW-1:0]  high_q;
    logic signed [OW-1:0]   low_volt;
    logic [CW-1:0]          carr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_vld <= 1'b0;
            lat_res <= '0;
        end else begin
            lat_vld <= sample_valid;
            if (sample_valid) lat_res <= IW'(ref_in);
        end
    end

    hml_carrier #(.HALF(CARR_HALF), .CW(CW)) u_carrier (
        .clk(clk), .rst_n(rst_n), .carr(carr)
    );

    for (genvar s = 0; s < NS; s++) begin : g_stage
        localparam int J = N_CELLS - 1 - s;
        if (s == 0) begin : g_first
            hml_step_cell #(
                .LEVELS(int'(LV_X[8*J +: 8])), .STEP(int'(ST_X[8*J +: 8])),
                .OFFS_HALF(half_offset(LV_X, ST_X, J)), .SLOT(J),
                .N_CELLS(N_CELLS), .IW(IW), .OW(OW), .FRAC_W(FRAC_W)
            ) u_cell (
                .clk(clk), .rst_n(rst_n),
                .in_vld(lat_vld), .in_res(lat_res), .in_volts('0),
                .out_vld(stg_vld[s]), .out_res(stg_res[s]), .out_volts(stg_volts[s])
            );
        end else begin : g_next
            hml_step_cell #(
                .LEVELS(int'(LV_X[8*J +: 8])), .STEP(int'(ST_X[8*J +: 8])),
                .OFFS_HALF(half_offset(LV_X, ST_X, J)), .SLOT(J),
                .N_CELLS(N_CELLS), .IW(IW), .OW(OW), .FRAC_W(FRAC_W)
            ) u_cell (
                .clk(clk), .rst_n(rst_n),
                .in_vld(stg_vld[s-1]), .in_res(stg_res[s-1]), .in_volts(stg_volts[s-1]),
                .out_vld(stg_vld[s]), .out_res(stg_res[s]), .out_volts(stg_volts[s])
            );
        end
    end

    hml_pwm_cell #(
        .LEVELS(int'(LV_X[7:0])), .IW(IW), .OW(OW), .FRAC_W(FRAC_W),
        .CARR_HALF(CARR_HALF), .CW(CW)
    ) u_low (
        .clk(clk), .rst_n(rst_n), .load(stg_vld[NS-1]), .res_in(stg_res[NS-1]),
        .carr(carr), .volt_out(low_volt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_q    <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= stg_vld[NS-1];
            if (stg_vld[NS-1]) high_q <= stg_volts[NS-1];
        end
    end

    always_comb begin
        int acc;
        cell_out          = high_q;
        cell_out[OW-1:0]  = low_volt;
        acc = 0;
        for (int c = 0; c < N_CELLS; c++) acc += int'($signed(cell_out[c*OW +: OW]));
        phase_out = OW'(acc);
    end

endmodule

// File: rtl/hml_checker.sv
module hml_checker
    import hml_pkg::*;
#(
    parameter int                   N_CELLS     = 3,
    parameter logic [8*N_CELLS-1:0] CELL_LEVELS = {8'd5, 8'd3, 8'd2},
    parameter logic [8*N_CELLS-1:0] CELL_STEPS  = {8'd3, 8'd1, 8'd1},
    parameter int                   OUT_W       = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sample_valid,
    input logic [N_CELLS*OUT_W-1:0] cell_out,
    input logic signed [OUT_W-1:0]  phase_out,
    input logic                     out_valid
);

    localparam logic [8*MAX_CELLS-1:0] LV_X = (8*MAX_CELLS)'(CELL_LEVELS);
    localparam logic [8*MAX_CELLS-1:0] ST_X = (8*MAX_CELLS)'(CELL_STEPS);
    localparam int SPAN = half_offset(LV_X, ST_X, N_CELLS);
    localparam int LOW_MAX = int'(LV_X[7:0]) - 1;

    logic [N_CELLS-1:0] strobe_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_sr <= '0;
        else        strobe_sr <= {strobe_sr[N_CELLS-2:0], sample_valid};
    end

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_sr[N_CELLS-1] |=> out_valid);

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_sr[N_CELLS-1] |=> !out_valid);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(cell_out[N_CELLS*OUT_W-1:OUT_W]));

    // R8
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(phase_out) <= SPAN) && (int'(phase_out) >= -SPAN));

    // R7
    low_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($signed(cell_out[OUT_W-1:0])) <= LOW_MAX) &&
        (int'($signed(cell_out[OUT_W-1:0])) >= -LOW_MAX));

    for (genvar j = 1; j < N_CELLS; j++) begin : g_cell_chk
        localparam int LIM = (int'(LV_X[8*j +: 8]) - 1) * int'(ST_X[8*j +: 8]);
        // R3
        step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (int'($signed(cell_out[j*OUT_W +: OUT_W])) <= LIM) &&
            (int'($signed(cell_out[j*OUT_W +: OUT_W])) >= -LIM));
    end

endmodule

bind hml_modulator hml_checker #(
    .N_CELLS(N_CELLS), .CELL_LEVELS(CELL_LEVELS), .CELL_STEPS(CELL_STEPS), .OUT_W(OUT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .cell_out(cell_out), .phase_out(phase_out), .out_valid(out_valid)
);

// File: tb/hml_modulator_tb.sv
`timescale 1ns/1ps

module hml_ref_model #(
    parameter int                   N_CELLS     = 3,
    parameter logic [8*N_CELLS-1:0] CELL_LEVELS = {8'd5, 8'd3, 8'd2},
    parameter logic [8*N_CELLS-1:0] CELL_STEPS  = {8'd3, 8'd1, 8'd1},
    parameter int                   FRAC_W      = 10,
    parameter int                   OUT_W       = 8,
    parameter int                   CARR_HALF   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_valid,
    input  logic signed [15:0]       ref_in,
    output logic [N_CELLS*OUT_W-1:0] exp_cells,
    output int                       exp_phase,
    output logic                     exp_valid
);
    typedef struct {int due; int res; int v[8];} pend_t;
    pend_t q[$];
    int cyc, car, held_res;
    bit up, armed;
    int held[8];
    int low;

    function automatic int lv(int j); return int'(CELL_LEVELS[8*j +: 8]); endfunction
    function automatic int st(int j); return int'(CELL_STEPS[8*j +: 8]); endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.delete(); cyc = 0; car = 0; up = 1; armed = 0; held_res = 0; low = 0;
            for (int i = 0; i < 8; i++) held[i] = 0;
            exp_cells <= '0; exp_phase <= 0; exp_valid <= 1'b0;
        end else begin
            int hu, one, r, sum;
            bit vld;
            pend_t p;
            hu = 1 << (FRAC_W - 1); one = 1 << FRAC_W;
            if (sample_valid) begin
                r = int'(ref_in);
                for (int i = 0; i < 8; i++) p.v[i] = 0;
                for (int j = N_CELLS - 1; j >= 1; j--) begin
                    int m, v, d, mag, lvl, best;
                    m = lv(j); v = st(j); d = 0;
                    for (int k = 0; k < j; k++) d += (lv(k) - 1) * st(k);
                    mag = (r < 0) ? -r : r;
                    best = 0;
                    if (m % 2 == 1) begin
                        for (lvl = 1; lvl <= (m - 1) / 2; lvl++)
                            if (mag >= d * hu + (lvl - 1) * v * one) best = lvl;
                        best = 2 * best * v;
                    end else begin
                        for (lvl = 1; lvl <= (m - 2) / 2; lvl++)
                            if (mag >= d * hu + (2 * lvl - 1) * v * hu) best = lvl;
                        best = (2 * best + 1) * v;
                    end
                    if (r < 0) best = -best;
                    p.v[j] = best;
                    r = r - best * hu;
                end
                p.res = r; p.due = cyc + N_CELLS;
                q.push_back(p);
            end
            vld = 0;
            if (q.size() > 0 && q[0].due == cyc) begin
                p = q.pop_front();
                for (int i = 0; i < 8; i++) held[i] = p.v[i];
                held_res = p.res; armed = 1; vld = 1;
            end
            if (armed) begin
                int m0, k, lo_u;
                m0 = lv(0);
                if (held_res >= (m0 - 1) * hu) low = m0 - 1;
                else if (held_res < -(m0 - 1) * hu) low = -(m0 - 1);
                else begin
                    k = 0;
                    for (int t = 0; t <= m0 - 2; t++)
                        if ((2 * t - (m0 - 1)) * hu <= held_res) k = t;
                    lo_u = (2 * k - (m0 - 1)) * hu;
                    if ((held_res - lo_u) * CARR_HALF > car * one) k = k + 1;
                    low = 2 * k - (m0 - 1);
                end
            end
            if (up) begin car++; if (car == CARR_HALF) up = 0; end
            else begin car--; if (car == 0) up = 1; end
            sum = low;
            for (int j = 1; j < N_CELLS; j++) sum += held[j];
            begin
                logic [N_CELLS*OUT_W-1:0] pk;
                pk = '0;
                pk[OUT_W-1:0] = OUT_W'(low);
                for (int j = 1; j < N_CELLS; j++) pk[j*OUT_W +: OUT_W] = OUT_W'(held[j]);
                exp_cells <= pk;
            end
            exp_phase <= sum;
            exp_valid <= vld;
            cyc++;
        end
    end
endmodule

module hml_modulator_tb;
    localparam int N  = 3;
    localparam int OW = 8;
    localparam int CH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_valid = 1'b0;
    logic signed [15:0] ref_in = '0;
    logic [N*OW-1:0] cell_out, cell_alt, exp_c, exp_ca;
    logic signed [OW-1:0] phase_out, phase_alt;
    logic out_valid, valid_alt, exp_v, exp_va;
    int exp_p, exp_pa;
    int n_chk = 0, n_fail = 0;
    bit running = 0, done = 0;
    logic [31:0] seen = '0;

    always #2.5 clk = ~clk;

    hml_modulator u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ref_in(ref_in),
        .cell_out(cell_out), .phase_out(phase_out), .out_valid(out_valid));

    hml_modulator #(.CELL_LEVELS({8'd4, 8'd3, 8'd2}), .CELL_STEPS({8'd3, 8'd1, 8'd1})) u_dut_alt (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ref_in(ref_in),
        .cell_out(cell_alt), .phase_out(phase_alt), .out_valid(valid_alt));

    hml_ref_model u_model (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ref_in(ref_in),
        .exp_cells(exp_c), .exp_phase(exp_p), .exp_valid(exp_v));

    hml_ref_model #(.CELL_LEVELS({8'd4, 8'd3, 8'd2}), .CELL_STEPS({8'd3, 8'd1, 8'd1})) u_model_alt (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ref_in(ref_in),
        .exp_cells(exp_ca), .exp_phase(exp_pa), .exp_valid(exp_va));

    task automatic chk(string req, string what, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    function automatic int slot(logic [N*OW-1:0] v, int j);
        return int'($signed(v[j*OW +: OW]));
    endfunction

    // Cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (running) begin
            chk("R3", "top cell", slot(cell_out, 2), slot(exp_c, 2));
            chk("R5", "middle cell", slot(cell_out, 1), slot(exp_c, 1));
            chk("R6", "lowest cell", slot(cell_out, 0), slot(exp_c, 0));
            chk("R8", "phase", int'(phase_out), exp_p);
            chk("R2", "out_valid", int'(out_valid), int'(exp_v));
            chk("R4", "alt top cell", slot(cell_alt, 2), slot(exp_ca, 2));
            chk("R5", "alt middle cell", slot(cell_alt, 1), slot(exp_ca, 1));
            chk("R6", "alt lowest cell", slot(cell_alt, 0), slot(exp_ca, 0));
            chk("R8", "alt phase", int'(phase_alt), exp_pa);
            if (int'(phase_out) >= -15 && int'(phase_out) <= 15 && (int'(phase_out) % 2 != 0))
                seen[int'(phase_out) + 15] = 1'b1;
        end
    end

    task automatic strobe(int r, int hold);
        ref_in = 16'(r);
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int cnt, odd_seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "cells in reset", int'(cell_out), 0);
        chk("R1", "phase in reset", int'(phase_out), 0);
        chk("R1", "valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        running = 1;
        repeat (6) @(negedge clk);
        chk("R1", "lowest cell idle before first result", slot(cell_out, 0), 0);
        chk("R1", "alt idle before first result", int'(cell_alt), 0);

        // R2 exact latency
        strobe(2000, 1);
        repeat (2) @(negedge clk);
        chk("R2", "no result one cycle early", int'(out_valid), 0);
        @(negedge clk);
        chk("R2", "result at latency", int'(out_valid), 1);
        @(negedge clk);
        chk("R2", "single-cycle valid", int'(out_valid), 0);
        repeat (40) @(negedge clk);

        // Slow ramp across the full range (R3 R5 R6 R8)
        for (int k = -160; k <= 160; k++) strobe(k * 51, 40);

        // Sine with varying amplitude
        for (int k = 0; k < 200; k++) begin
            real a;
            a = (0.3 + 7.3 * (k % 50) / 49.0) * 1024.0;
            strobe($rtoi(a * $sin(6.2831853 * k / 25.0)), 37);
        end

        // R9 consecutive strobes
        cnt = 0;
        fork
            begin
                for (int k = 0; k < 6; k++) strobe(k * 1300 - 3000, 1);
            end
            begin
                repeat (12) begin @(negedge clk); if (out_valid) cnt++; end
            end
        join
        chk("R9", "results for back-to-back strobes", cnt, 6);
        repeat (20) @(negedge clk);

        // R7 saturation above and below
        strobe(9216, 5);
        for (int k = 0; k < 2 * CH + 2; k++) begin
            chk("R7", "lowest cell pinned high", slot(cell_out, 0), 1);
            @(negedge clk);
        end
        strobe(-9216, 5);
        for (int k = 0; k < 2 * CH + 2; k++) begin
            chk("R7", "lowest cell pinned low", slot(cell_out, 0), -1);
            @(negedge clk);
        end

        // R4 even-level top cell on the alternate instance
        strobe(0, 6);
        chk("R4", "even cell at zero reference", slot(cell_alt, 2), 3);
        strobe(-103, 6);
        chk("R4", "even cell negative reference", slot(cell_alt, 2), -3);
        strobe(3072, 6);
        chk("R4", "even cell at threshold", slot(cell_alt, 2), 9);
        strobe(3071, 6);
        chk("R4", "even cell just below threshold", slot(cell_alt, 2), 3);
        strobe(-3072, 6);
        chk("R4", "even cell mirrored threshold", slot(cell_alt, 2), -9);

        // R3 odd top cell threshold edges (1.5 pu and 4.5 pu)
        strobe(1536, 6);
        chk("R3", "odd cell at first threshold", slot(cell_out, 2), 6);
        strobe(1535, 6);
        chk("R3", "odd cell below first threshold", slot(cell_out, 2), 0);
        strobe(-4608, 6);
        chk("R3", "odd cell mirrored second threshold", slot(cell_out, 2), -12);

        // R8 level coverage
        odd_seen = $countones(seen);
        chk("R8", "distinct phase levels reached", odd_seen, 16);

        running = 0;
        finish_run();
    end
endmodule